// File: doc/BRIEF.md
# Protected Register Unlock Sequencer

This block keeps one 8-bit control register behind a guarded store sequence on a simple peripheral write bus. The bus carries an address, a data byte and a one-cycle write strobe. A read address selects what the combinational read port returns. Software unlocks the guarded register in four steps, each of which must be the very next peripheral store:

- write the key byte 0xA5 to the command location;
- write the new value to the guarded register;
- write the bitwise inverse of that value to the guarded register;
- write the value again to the guarded register.

On the clock edge of the last correct store, the guarded register takes the value. The sequencer then returns to idle.

Any store that breaks the sequence does three things. It returns the sequencer to idle, it leaves the guarded register unchanged, and it raises a sticky protection-error flag. The offending store is a store to the wrong location, a wrong value, or a command write without the key. A status register holds that flag together with two more sticky error flags. Those two flags are raised by external one-cycle pulses that report verify failures and write/erase-protect failures. Each flag is cleared by writing 0 to its bit.

Top module: `prot_unlock_seq`

## Requirements
- R1: After reset the status register reads 0x00 and the guarded register output holds 0x00.
- R2: The guarded register output changes only on the clock edge of the third correct store after the key. The three stores are the value, then its bitwise inverse, then the value again. It shows the new value from the following cycle.
- R3: After the key, a store to any location other than the guarded register raises status bit 0 and returns the sequencer to idle. This includes a store to the status register. The guarded register keeps its value.
- R4: At the second step, a store to the guarded register whose value is not the bitwise inverse raises status bit 0 without a commit. The same holds at the third step for a value that differs from the first one.
- R5: A command write whose data is not 0xA5 raises status bit 0. A store to the guarded register while no sequence is open raises status bit 0 and is ignored.
- R6: After a failed step the sequencer starts again from idle. A value/inverse/value series sent without a new key does not commit.
- R7: The status register is read at the command address plus one. Its bits 7 to 3 always read 0. A read at the command address returns 0x00. A read at the guarded register address returns its value.
- R8: Writing 0 to a status bit clears that flag. Writing 1 to a status bit leaves it unchanged.
- R9: A pulse on `verify_err_set` raises status bit 1, and a pulse on `wprot_err_set` raises status bit 2. When a pulse and a clear of the same bit arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one store per cycle it is high |
| wr_addr | input | 16 | Store address |
| wr_data | input | 8 | Store data |
| rd_addr | input | 16 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| verify_err_set | input | 1 | Pulse that raises the verify-error flag |
| wprot_err_set | input | 1 | Pulse that raises the write/erase-protect-error flag |
| ctrl_q | output | 8 | Current value of the guarded register |

## Verification
Every result of this block falls due exactly one clock edge after the store or pulse that causes it. This applies to the commit of the guarded register, the raising of any flag, and the clearing of a flag by a zero write. The read port is combinational, so it shows register state in the same cycle. The bench drives each store or pulse on a falling edge. It lets one rising edge capture the store or pulse, then samples outputs and the read port at the next falling edge. The bench also checks the guarded register after the second step, which shows that no commit happens one step early.

// File: rtl/pus_pkg.sv
package pus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_KEYED = 2'd1,
        ST_VAL   = 2'd2,
        ST_INV   = 2'd3
    } seq_state_e;

    localparam int unsigned FLAG_PERR  = 0;
    localparam int unsigned FLAG_VERR  = 1;
    localparam int unsigned FLAG_WPERR = 2;
    localparam int unsigned NUM_FLAGS  = 3;

    typedef struct packed {
        logic cmd;
        logic stat;
        logic ctrl;
    } addr_hit_t;

endpackage

// File: rtl/pus_addr_dec.sv
module pus_addr_dec #(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 16'hFFA0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFFC4
) (
    input  logic [ADDR_W-1:0] addr,
    output pus_pkg::addr_hit_t hit
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = CMD_ADDR + 1'b1;

    always_comb begin
        hit.cmd  = (addr == CMD_ADDR);
        hit.stat = (addr == STAT_ADDR);
        hit.ctrl = (addr == CTRL_ADDR);
    end
endmodule

// File: rtl/pus_seq_fsm.sv
module pus_seq_fsm #(
    parameter int unsigned DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY = 8'hA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              hit_cmd,
    input  logic              hit_ctrl,
    input  logic [DATA_W-1:0] wr_data,
    output logic              commit,
    output logic [DATA_W-1:0] commit_val,
    output logic              perr_set
);
    import pus_pkg::*;

    seq_state_e        st_q, st_d;
    logic [DATA_W-1:0] val_q, val_d;

    always_comb begin
        st_d     = st_q;
        val_d    = val_q;
        commit   = 1'b0;
        perr_set = 1'b0;
        if (wr_en) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (hit_cmd) begin
                        if (wr_data == KEY) st_d = ST_KEYED;
                        else                perr_set = 1'b1;
                    end else if (hit_ctrl) begin
                        perr_set = 1'b1;
                    end
                end
                ST_KEYED: begin
                    if (hit_ctrl) begin
                        val_d = wr_data;
                        st_d  = ST_VAL;
                    end else begin
                        perr_set = 1'b1;
                        st_d     = ST_IDLE;
                    end
                end
                ST_VAL: begin
                    if (hit_ctrl && (wr_data == ~val_q)) begin
                        st_d = ST_INV;
                    end else begin
                        perr_set = 1'b1;
                        st_d     = ST_IDLE;
                    end
                end
                ST_INV: begin
                    if (hit_ctrl && (wr_data == val_q)) commit = 1'b1;
                    else                                perr_set = 1'b1;
                    st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    assign commit_val = val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            val_q <= '0;
        end else begin
            st_q  <= st_d;
            val_q <= val_d;
        end
    end
endmodule

// File: rtl/pus_flag_bank.sv
module pus_flag_bank #(
    parameter int unsigned NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] set_i,
    input  logic             clr_we,
    input  logic [NFLAG-1:0] clr_data,
    output logic [NFLAG-1:0] flags_q
);
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)                         flags_q[g] <= 1'b0;
            else if (set_i[g])               flags_q[g] <= 1'b1;
            else if (clr_we && !clr_data[g]) flags_q[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/prot_unlock_seq.sv
module prot_unlock_seq #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 16'hFFA0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFFC4,
    parameter logic [DATA_W-1:0] KEY       = 8'hA5,
    parameter logic [DATA_W-1:0] CTRL_RST  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              verify_err_set,
    input  logic              wprot_err_set,
    output logic [DATA_W-1:0] ctrl_q
);
    import pus_pkg::*;

    localparam int unsigned PAD_W = DATA_W - NUM_FLAGS;

    addr_hit_t             wr_hit, rd_hit;
    logic                  commit, perr_set;
    logic [DATA_W-1:0]     commit_val;
    logic [NUM_FLAGS-1:0]  flag_set, flags;

    pus_addr_dec #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .CTRL_ADDR(CTRL_ADDR))
        u_wr_dec (.addr(wr_addr), .hit(wr_hit));

    pus_addr_dec #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .CTRL_ADDR(CTRL_ADDR))
        u_rd_dec (.addr(rd_addr), .hit(rd_hit));

    pus_seq_fsm #(.DATA_W(DATA_W), .KEY(KEY)) u_fsm (
        .clk(clk), .rst(rst), .wr_en(wr_en),
        .hit_cmd(wr_hit.cmd), .hit_ctrl(wr_hit.ctrl), .wr_data(wr_data),
        .commit(commit), .commit_val(commit_val), .perr_set(perr_set)
    );

    always_comb begin
        flag_set             = '0;
        flag_set[FLAG_PERR]  = perr_set;
        flag_set[FLAG_VERR]  = verify_err_set;
        flag_set[FLAG_WPERR] = wprot_err_set;
    end

    pus_flag_bank #(.NFLAG(NUM_FLAGS)) u_flags (
        .clk(clk), .rst(rst), .set_i(flag_set),
        .clr_we(wr_en && wr_hit.stat), .clr_data(wr_data[NUM_FLAGS-1:0]),
        .flags_q(flags)
    );

    always_ff @(posedge clk) begin
        if (rst)         ctrl_q <= CTRL_RST;
        else if (commit) ctrl_q <= commit_val;
    end

    always_comb begin
        if (rd_hit.stat)      rd_data = {{PAD_W{1'b0}}, flags};
        else if (rd_hit.ctrl) rd_data = ctrl_q;
        else                  rd_data = '0;
    end
endmodule

// File: rtl/pus_chk.sv
module pus_chk #(
    parameter int unsigned DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY      = 8'hA5,
    parameter logic [DATA_W-1:0] CTRL_RST = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              hit_cmd,
    input logic              hit_stat,
    input logic              hit_ctrl,
    input logic [DATA_W-1:0] wr_data,
    input logic              verify_err_set,
    input logic              wprot_err_set,
    input logic [2:0]        flags,
    input logic [DATA_W-1:0] ctrl_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (flags == 3'b000 && ctrl_q == CTRL_RST));

    // R2
    ctrl_only_on_store_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_q) |-> $past(wr_en && hit_ctrl));

    // R5
    bad_key_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit_cmd && wr_data != KEY) |=> flags[0]);

    // R9
    verr_set_chk: assert property (@(posedge clk) disable iff (rst)
        verify_err_set |=> flags[1]);

    // R9
    wperr_set_chk: assert property (@(posedge clk) disable iff (rst)
        wprot_err_set |=> flags[2]);

    // R8
    verr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit_stat && !wr_data[1] && !verify_err_set) |=> !flags[1]);

    // R8
    verr_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[1]) |-> $past(verify_err_set));
endmodule

bind prot_unlock_seq pus_chk #(.DATA_W(DATA_W), .KEY(KEY), .CTRL_RST(CTRL_RST)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .hit_cmd(wr_hit.cmd), .hit_stat(wr_hit.stat), .hit_ctrl(wr_hit.ctrl),
    .wr_data(wr_data), .verify_err_set(verify_err_set),
    .wprot_err_set(wprot_err_set), .flags(flags), .ctrl_q(ctrl_q)
);

// File: tb/prot_unlock_seq_bench.sv
module prot_unlock_seq_bench;
    localparam logic [15:0] CMD  = 16'hFFA0;
    localparam logic [15:0] STAT = 16'hFFA1;
    localparam logic [15:0] CTRL = 16'hFFC4;
    localparam logic [15:0] OTHR = 16'h0010;

    logic        clk = 1'b0, rst = 1'b1;
    logic        wr_en = 1'b0, verify_err_set = 1'b0, wprot_err_set = 1'b0;
    logic [15:0] wr_addr = '0, rd_addr = '0;
    logic [7:0]  wr_data = '0, rd_data, ctrl_q;
    int          n_checks = 0, n_errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    prot_unlock_seq u_prot_unlock_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .verify_err_set(verify_err_set),
        .wprot_err_set(wprot_err_set), .ctrl_q(ctrl_q)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one store, captured by the next rising edge; returns on the falling edge after
    task automatic store(input logic [15:0] a, input logic [7:0] d,
                         input logic vp = 1'b0, input logic wp = 1'b0);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        verify_err_set = vp; wprot_err_set = wp;
        @(negedge clk);
        wr_en = 1'b0; verify_err_set = 1'b0; wprot_err_set = 1'b0;
    endtask

    task automatic pulse(input logic vp, input logic wp);
        verify_err_set = vp; wprot_err_set = wp;
        @(negedge clk);
        verify_err_set = 1'b0; wprot_err_set = 1'b0;
    endtask

    task automatic read(input logic [15:0] a, output logic [7:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic unlock(input logic [7:0] v);
        store(CMD, 8'hA5); store(CTRL, v); store(CTRL, ~v); store(CTRL, v);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        read(STAT, r); check("R1 status after reset", r, 8'h00);
        check("R1 ctrl after reset", ctrl_q, 8'h00);
    endtask

    task automatic t_commit();
        logic [7:0] r;
        store(CMD, 8'hA5); store(CTRL, 8'h3C); store(CTRL, 8'hC3);
        check("R2 no commit before third store", ctrl_q, 8'h00);
        store(CTRL, 8'h3C);
        check("R2 commit", ctrl_q, 8'h3C);
        read(STAT, r); check("R2 no error on good sequence", r, 8'h00);
        read(CTRL, r); check("R7 ctrl read back", r, 8'h3C);
    endtask

    task automatic t_wrong_addr();
        logic [7:0] r;
        store(CMD, 8'hA5); store(CTRL, 8'h11); store(OTHR, 8'hEE);
        read(STAT, r); check("R3 other address aborts", r, 8'h01);
        store(CTRL, 8'h11);
        check("R3 ctrl unchanged", ctrl_q, 8'h3C);
        store(STAT, 8'h00);
        read(STAT, r); check("R8 clear perr", r, 8'h00);
        store(CMD, 8'hA5); store(STAT, 8'h00);
        read(STAT, r); check("R3 status store inside sequence aborts", r, 8'h01);
        store(STAT, 8'h00);
    endtask

    task automatic t_wrong_val();
        logic [7:0] r;
        store(CMD, 8'hA5); store(CTRL, 8'h42); store(CTRL, 8'h42);
        read(STAT, r); check("R4 non-inverse at step two", r, 8'h01);
        store(STAT, 8'h00);
        store(CMD, 8'hA5); store(CTRL, 8'h42); store(CTRL, 8'hBD); store(CTRL, 8'h43);
        read(STAT, r); check("R4 mismatch at step three", r, 8'h01);
        check("R4 ctrl unchanged", ctrl_q, 8'h3C);
        store(STAT, 8'h00);
    endtask

    task automatic t_bad_cmd();
        logic [7:0] r;
        store(CMD, 8'h5A);
        read(STAT, r); check("R5 command without key", r, 8'h01);
        store(STAT, 8'h00);
        store(CTRL, 8'h99);
        read(STAT, r); check("R5 guarded store while idle", r, 8'h01);
        check("R5 guarded store ignored", ctrl_q, 8'h3C);
        store(STAT, 8'h00);
    endtask

    task automatic t_restart();
        logic [7:0] r;
        store(CMD, 8'hA5); store(CTRL, 8'h77); store(OTHR, 8'h00);
        store(STAT, 8'h00);
        store(CTRL, 8'h77); store(CTRL, 8'h88); store(CTRL, 8'h77);
        check("R6 no commit without new key", ctrl_q, 8'h3C);
        store(STAT, 8'h00);
        unlock(8'h77);
        check("R6 commit after fresh key", ctrl_q, 8'h77);
        read(STAT, r); check("R6 clean after fresh key", r, 8'h00);
    endtask

    task automatic t_readmap();
        logic [7:0] r;
        store(CMD, 8'h00); pulse(1'b1, 1'b1);
        read(STAT, r); check("R7 all flags high bits zero", r, 8'h07);
        read(CMD, r); check("R7 command reads zero", r, 8'h00);
    endtask

    task automatic t_clear();
        logic [7:0] r;
        store(STAT, 8'hFF);
        read(STAT, r); check("R8 writing ones holds", r, 8'h07);
        store(STAT, 8'hFD);
        read(STAT, r); check("R8 per-bit clear", r, 8'h05);
        store(STAT, 8'h00);
        read(STAT, r); check("R8 clear all", r, 8'h00);
    endtask

    task automatic t_pulses();
        logic [7:0] r;
        pulse(1'b1, 1'b0);
        read(STAT, r); check("R9 verify pulse", r, 8'h02);
        pulse(1'b0, 1'b1);
        read(STAT, r); check("R9 protect pulse", r, 8'h06);
        store(STAT, 8'h00, 1'b1, 1'b0);
        read(STAT, r); check("R9 set wins over clear", r, 8'h02);
        store(STAT, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_commit();
        t_wrong_addr();
        t_wrong_val();
        t_bad_cmd();
        t_restart();
        t_readmap();
        t_clear();
        t_pulses();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule